// File: doc/BRIEF.md
# MESI Snooping Cache Coherence Controller

This block keeps the coherence state of every line in a small direct-mapped write-back cache. Each line is in one of four states: Invalid, Shared (clean, other caches may also hold it), Exclusive (clean, no other cache holds it) or Modified (dirty, the only valid copy). The block serves processor read and write requests, answers hit or miss, and issues bus commands for fills, ownership requests and write-backs. It does not store data, arbitrate the bus, model memory, or decide which of several caches supplies data.

In parallel it watches bus transactions from other caches. A snooped read that finds a valid local copy drives the wired shared line, and a Modified copy also raises a flush request. A snooped read-exclusive invalidates the local copy. On its own bus reads the block samples the shared line when the bus acknowledges the read. If no other cache holds the line, the line is filled as Exclusive. A later write to that line then needs no bus transaction.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, no bus command is pending (bus_cmd 0), resp_valid, snp_shared and snp_flush are low, and req_ready is high.
- R2: A read of a line that is not present issues bus_cmd 1 (read) with the line address. On its acknowledge the line becomes Exclusive (resp_state 2) if bus_shared is low, or Shared (resp_state 1) if it is high. resp_hit is 0.
- R3: A write to a line that is Invalid, absent or Shared issues bus_cmd 2 (read-exclusive). On its acknowledge the line becomes Modified (resp_state 3), whatever bus_shared is, and resp_hit is 0.
- R4: A write to an Exclusive line issues no bus command, answers resp_hit 1 and leaves the line Modified.
- R5: Read hits in Modified, Exclusive or Shared, and write hits in Modified, issue no bus command, answer resp_hit 1 and report the unchanged state.
- R6: A snooped read (snp_excl 0) that hits a valid line raises snp_shared in the next cycle and leaves the line Shared.
- R7: A snooped read or read-exclusive that hits a Modified line raises snp_flush in the next cycle, with the line address on snp_flush_addr.
- R8: A snooped read-exclusive (snp_excl 1) that hits a valid line leaves it Invalid and does not raise snp_shared.
- R9: A snoop whose tag does not match, or whose line is Invalid, raises neither snp_shared nor snp_flush and changes no line.
- R10: A miss whose victim line is Modified first issues bus_cmd 3 (write-back) with the victim address, then the fill command after its acknowledge. A victim that is Exclusive or Shared is dropped with no write-back.
- R11: req_ready is low while a bus command is outstanding, and low in a cycle where a snoop targets the same index as the request. The bus never acknowledges and presents a snoop in the same cycle.
- R12: A request that needs no bus command answers with resp_valid in the cycle after it is accepted. A request that needs one answers with resp_valid in the cycle after the acknowledge of the fill command. Bus commands hold their value and address until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | LINE_AW | Line address {tag, index} |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | 1 when the request needed no bus command |
| resp_state | output | 2 | Line state after the access: 0 I, 1 S, 2 E, 3 M |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-exclusive, 3 write-back |
| bus_addr | output | LINE_AW | Address of the bus command |
| bus_ack | input | 1 | Bus has completed the current command |
| bus_shared | input | 1 | Wired shared line, sampled with bus_ack |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_excl | input | 1 | 1 = read-exclusive, 0 = read |
| snp_addr | input | LINE_AW | Snooped line address |
| snp_shared | output | 1 | Drive of the wired shared line |
| snp_flush | output | 1 | This cache must supply the Modified data |
| snp_flush_addr | output | LINE_AW | Address of the line to flush |

## Verification
The bench targets the transitions that a faulty controller gets wrong in ways that are easy to miss. A read filled with the shared line high must give Shared, not Exclusive; the reverse error would let a later write skip its read-exclusive and corrupt another cache's copy. A write to an Exclusive line must stay off the bus, while a write to a Shared line must not. A snooped read-exclusive must invalidate without answering shared, and a snoop with a mismatched tag must leave the local line alone. Evictions of Modified lines must write back before the fill, Exclusive and Shared victims must be dropped silently, and a snoop to the requested index must hold the request off.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_WB   = 2'd3
  } bus_cmd_t;

  typedef enum logic [1:0] {
    P_IDLE = 2'd0,
    P_WB   = 2'd1,
    P_FILL = 2'd2
  } pstate_t;

  // State left behind by a snoop that hit a valid line
  function automatic line_st_t snoop_next(input line_st_t cur, input logic excl);
    if (excl || cur == ST_I) return ST_I;
    return ST_S;
  endfunction

  // State a fill installs; the shared sample matters only for reads
  function automatic line_st_t fill_state(input logic wr, input logic shared);
    if (wr) return ST_M;
    return shared ? ST_S : ST_E;
  endfunction

  function automatic bus_cmd_t fill_cmd(input logic wr);
    return wr ? CMD_RDX : CMD_RD;
  endfunction

endpackage

// File: rtl/mesi_line_table.sv
module mesi_line_table
  import mesi_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  // read port A (processor side)
  input  logic [IDX_W-1:0] a_idx,
  output line_st_t         a_st,
  output logic [TAG_W-1:0] a_tag,
  // read port B (snoop side)
  input  logic [IDX_W-1:0] b_idx,
  output line_st_t         b_st,
  output logic [TAG_W-1:0] b_tag,
  // write port A: state and tag
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_widx,
  input  line_st_t         a_wst,
  input  logic             a_tag_we,
  input  logic [TAG_W-1:0] a_wtag,
  // write port B: state only, wins on equal index
  input  logic             b_we,
  input  logic [IDX_W-1:0] b_widx,
  input  line_st_t         b_wst
);

  localparam int LINES = 1 << IDX_W;

  line_st_t         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else begin
      if (a_we) st_q[a_widx] <= a_wst;
      if (b_we) st_q[b_widx] <= b_wst;
    end
  end

  // tags need no reset: an Invalid state masks them
  always_ff @(posedge clk) begin
    if (a_tag_we) tag_q[a_widx] <= a_wtag;
  end

  assign a_st  = st_q[a_idx];
  assign a_tag = tag_q[a_idx];
  assign b_st  = st_q[b_idx];
  assign b_tag = tag_q[b_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int LINE_AW = 12,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               snp_valid,
  input  logic               snp_excl,
  input  logic [LINE_AW-1:0] snp_addr,
  // table lookup
  output logic [IDX_W-1:0]   lk_idx,
  input  line_st_t           lk_st,
  input  logic [LINE_AW-IDX_W-1:0] lk_tag,
  // table update
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output line_st_t           wr_st,
  // registered responses
  output logic               shared_q,
  output logic               flush_q,
  output logic [LINE_AW-1:0] flush_addr_q
);

  localparam int TAG_W = LINE_AW - IDX_W;

  logic [TAG_W-1:0] s_tag;
  logic             s_hit;

  assign lk_idx = snp_addr[IDX_W-1:0];
  assign s_tag  = snp_addr[LINE_AW-1:IDX_W];
  assign s_hit  = snp_valid && (lk_st != ST_I) && (lk_tag == s_tag);

  assign wr_en  = s_hit;
  assign wr_idx = lk_idx;
  assign wr_st  = snoop_next(lk_st, snp_excl);

  always_ff @(posedge clk) begin
    if (rst) begin
      shared_q     <= 1'b0;
      flush_q      <= 1'b0;
      flush_addr_q <= '0;
    end else begin
      shared_q <= s_hit && !snp_excl;
      flush_q  <= s_hit && (lk_st == ST_M);
      if (s_hit && lk_st == ST_M) flush_addr_q <= snp_addr;
    end
  end

endmodule

// File: rtl/mesi_proc_fsm.sv
module mesi_proc_fsm
  import mesi_pkg::*;
#(
  parameter int LINE_AW = 12,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [LINE_AW-1:0] req_addr,
  output logic               req_ready,
  input  logic               snp_valid,
  input  logic [LINE_AW-1:0] snp_addr,
  // table lookup
  output logic [IDX_W-1:0]   lk_idx,
  input  line_st_t           lk_st,
  input  logic [LINE_AW-IDX_W-1:0] lk_tag,
  // table update
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output line_st_t           wr_st,
  output logic               wr_tag_en,
  output logic [LINE_AW-IDX_W-1:0] wr_tag,
  // bus side
  input  logic               bus_ack,
  input  logic               bus_shared,
  output bus_cmd_t           bus_cmd_q,
  output logic [LINE_AW-1:0] bus_addr_q,
  // response
  output logic               resp_valid_q,
  output logic               resp_hit_q,
  output line_st_t           resp_state_q
);

  localparam int TAG_W = LINE_AW - IDX_W;

  pstate_t            ps_q;
  logic [LINE_AW-1:0] pend_addr_q;
  logic               pend_write_q;

  logic [IDX_W-1:0] r_idx;
  logic [TAG_W-1:0] r_tag;
  logic             hit, fast, to_mod, need_wb, accept;

  assign r_idx   = req_addr[IDX_W-1:0];
  assign r_tag   = req_addr[LINE_AW-1:IDX_W];
  assign lk_idx  = r_idx;
  assign hit     = (lk_st != ST_I) && (lk_tag == r_tag);
  assign fast    = hit && (!req_write || lk_st != ST_S);
  assign to_mod  = hit && req_write && (lk_st == ST_E);
  assign need_wb = !hit && (lk_st == ST_M);

  assign req_ready = (ps_q == P_IDLE) &&
                     !(snp_valid && snp_addr[IDX_W-1:0] == r_idx);
  assign accept    = req_valid && req_ready;

  always_comb begin
    wr_en     = 1'b0;
    wr_idx    = pend_addr_q[IDX_W-1:0];
    wr_st     = ST_I;
    wr_tag_en = 1'b0;
    wr_tag    = pend_addr_q[LINE_AW-1:IDX_W];
    case (ps_q)
      P_IDLE: begin
        if (accept && to_mod) begin
          wr_en  = 1'b1;
          wr_idx = r_idx;
          wr_st  = ST_M;
        end
      end
      P_WB: begin
        if (bus_ack) begin
          wr_en = 1'b1;
          wr_st = ST_I;
        end
      end
      P_FILL: begin
        if (bus_ack) begin
          wr_en     = 1'b1;
          wr_tag_en = 1'b1;
          wr_st     = fill_state(pend_write_q, bus_shared);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q         <= P_IDLE;
      pend_addr_q  <= '0;
      pend_write_q <= 1'b0;
      bus_cmd_q    <= CMD_NONE;
      bus_addr_q   <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_state_q <= ST_I;
    end else begin
      resp_valid_q <= 1'b0;
      case (ps_q)
        P_IDLE: begin
          if (accept) begin
            pend_addr_q  <= req_addr;
            pend_write_q <= req_write;
            if (fast) begin
              resp_valid_q <= 1'b1;
              resp_hit_q   <= 1'b1;
              resp_state_q <= to_mod ? ST_M : lk_st;
            end else if (need_wb) begin
              bus_cmd_q  <= CMD_WB;
              bus_addr_q <= {lk_tag, r_idx};
              ps_q       <= P_WB;
            end else begin
              bus_cmd_q  <= fill_cmd(req_write);
              bus_addr_q <= req_addr;
              ps_q       <= P_FILL;
            end
          end
        end
        P_WB: begin
          if (bus_ack) begin
            bus_cmd_q  <= fill_cmd(pend_write_q);
            bus_addr_q <= pend_addr_q;
            ps_q       <= P_FILL;
          end
        end
        P_FILL: begin
          if (bus_ack) begin
            bus_cmd_q    <= CMD_NONE;
            resp_valid_q <= 1'b1;
            resp_hit_q   <= 1'b0;
            resp_state_q <= fill_state(pend_write_q, bus_shared);
            ps_q         <= P_IDLE;
          end
        end
        default: ps_q <= P_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int LINE_AW = 12,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [LINE_AW-1:0] req_addr,
  output logic               req_ready,
  output logic               resp_valid,
  output logic               resp_hit,
  output logic [1:0]         resp_state,
  output logic [1:0]         bus_cmd,
  output logic [LINE_AW-1:0] bus_addr,
  input  logic               bus_ack,
  input  logic               bus_shared,
  input  logic               snp_valid,
  input  logic               snp_excl,
  input  logic [LINE_AW-1:0] snp_addr,
  output logic               snp_shared,
  output logic               snp_flush,
  output logic [LINE_AW-1:0] snp_flush_addr
);

  localparam int TAG_W = LINE_AW - IDX_W;

  logic [IDX_W-1:0] pa_idx, sb_idx, pw_idx, sw_idx;
  line_st_t         pa_st, sb_st, pw_st, sw_st;
  logic [TAG_W-1:0] pa_tag, sb_tag, pw_tag;
  logic             pw_en, pw_tag_en, sw_en;
  bus_cmd_t         cmd_q;
  line_st_t         rstate_q;

  mesi_line_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .a_idx    (pa_idx),
    .a_st     (pa_st),
    .a_tag    (pa_tag),
    .b_idx    (sb_idx),
    .b_st     (sb_st),
    .b_tag    (sb_tag),
    .a_we     (pw_en),
    .a_widx   (pw_idx),
    .a_wst    (pw_st),
    .a_tag_we (pw_tag_en),
    .a_wtag   (pw_tag),
    .b_we     (sw_en),
    .b_widx   (sw_idx),
    .b_wst    (sw_st)
  );

  mesi_proc_fsm #(.LINE_AW(LINE_AW), .IDX_W(IDX_W)) u_proc (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_ready    (req_ready),
    .snp_valid    (snp_valid),
    .snp_addr     (snp_addr),
    .lk_idx       (pa_idx),
    .lk_st        (pa_st),
    .lk_tag       (pa_tag),
    .wr_en        (pw_en),
    .wr_idx       (pw_idx),
    .wr_st        (pw_st),
    .wr_tag_en    (pw_tag_en),
    .wr_tag       (pw_tag),
    .bus_ack      (bus_ack),
    .bus_shared   (bus_shared),
    .bus_cmd_q    (cmd_q),
    .bus_addr_q   (bus_addr),
    .resp_valid_q (resp_valid),
    .resp_hit_q   (resp_hit),
    .resp_state_q (rstate_q)
  );

  mesi_snoop_unit #(.LINE_AW(LINE_AW), .IDX_W(IDX_W)) u_snoop (
    .clk          (clk),
    .rst          (rst),
    .snp_valid    (snp_valid),
    .snp_excl     (snp_excl),
    .snp_addr     (snp_addr),
    .lk_idx       (sb_idx),
    .lk_st        (sb_st),
    .lk_tag       (sb_tag),
    .wr_en        (sw_en),
    .wr_idx       (sw_idx),
    .wr_st        (sw_st),
    .shared_q     (snp_shared),
    .flush_q      (snp_flush),
    .flush_addr_q (snp_flush_addr)
  );

  assign bus_cmd    = cmd_q;
  assign resp_state = rstate_q;

endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
  parameter int LINE_AW = 12,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_write,
  input logic [LINE_AW-1:0] req_addr,
  input logic               req_ready,
  input logic               resp_valid,
  input logic               resp_hit,
  input logic [1:0]         resp_state,
  input logic [1:0]         bus_cmd,
  input logic [LINE_AW-1:0] bus_addr,
  input logic               bus_ack,
  input logic               bus_shared,
  input logic               snp_valid,
  input logic               snp_excl,
  input logic [LINE_AW-1:0] snp_addr,
  input logic               snp_shared,
  input logic               snp_flush,
  input logic [LINE_AW-1:0] snp_flush_addr
);

  AST_NO_SNOOP_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    !(snp_valid && bus_ack)); // R11

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd != 2'd0) |-> !req_ready); // R11

  AST_SHARED_FROM_READ_SNOOP: assert property (@(posedge clk) disable iff (rst)
    snp_shared |-> $past(snp_valid && !snp_excl)); // R6

  AST_FLUSH_FROM_SNOOP: assert property (@(posedge clk) disable iff (rst)
    snp_flush |-> ($past(snp_valid) && snp_flush_addr == $past(snp_addr))); // R7

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd != 2'd0 && !bus_ack) |=> ($stable(bus_cmd) && $stable(bus_addr))); // R12

  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> (bus_cmd == 2'd0 && resp_state != 2'd0)); // R5

  AST_MISS_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> ($past(bus_ack) && resp_state != 2'd0)); // R12

  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == 2'd3 && bus_ack) |=> (bus_cmd == 2'd1 || bus_cmd == 2'd2)); // R10

endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.LINE_AW(LINE_AW), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module test_mesi_snoop_ctrl;

  localparam int LINE_AW = 12;
  localparam int IDX_W   = 4;
  localparam int TAG_W   = LINE_AW - IDX_W;
  localparam int LINES   = 1 << IDX_W;
  // state codes: 0 I, 1 S, 2 E, 3 M ; commands: 0 none, 1 rd, 2 rdx, 3 wb

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [LINE_AW-1:0] req_addr = '0;
  logic req_ready, resp_valid, resp_hit;
  logic [1:0] resp_state, bus_cmd;
  logic [LINE_AW-1:0] bus_addr;
  logic bus_ack = 0, bus_shared = 0;
  logic snp_valid = 0, snp_excl = 0;
  logic [LINE_AW-1:0] snp_addr = '0;
  logic snp_shared, snp_flush;
  logic [LINE_AW-1:0] snp_flush_addr;

  always #4 clk = ~clk;

  mesi_snoop_ctrl #(.LINE_AW(LINE_AW), .IDX_W(IDX_W)) i_mesi_snoop_ctrl (.*);

  int n_chk = 0, n_fail = 0;
  int m_st  [LINES];
  int m_tag [LINES];

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int fill_st(input bit wr, input bit sh);
    if (wr) return 3;
    return sh ? 1 : 2;
  endfunction

  task automatic ack(input bit sh);
    repeat ($urandom % 3) @(negedge clk);
    bus_ack = 1; bus_shared = sh;
    @(negedge clk);
    bus_ack = 0; bus_shared = 0;
  endtask

  task automatic proc_op(input bit wr, input logic [LINE_AW-1:0] a, input bit sh);
    int idx, tg, st;
    bit hit;
    idx = int'(a[IDX_W-1:0]);
    tg  = int'(a[LINE_AW-1:IDX_W]);
    st  = m_st[idx];
    hit = (st != 0) && (m_tag[idx] == tg);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a;
    #1 chk("R11 ready when idle", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 0;
    if (hit && (!wr || st != 1)) begin
      chk("R12 hit response next cycle", int'(resp_valid), 1);
      chk(wr && st == 2 ? "R4 write E hit" : "R5 hit flag", int'(resp_hit), 1);
      chk(wr && st == 2 ? "R4 E becomes M" : "R5 state kept", int'(resp_state), wr ? 3 : st);
      chk(wr && st == 2 ? "R4 no bus" : "R5 no bus", int'(bus_cmd), 0);
      if (wr) m_st[idx] = 3;
    end else begin
      if (!hit && st == 3) begin
        chk("R10 write-back first", int'(bus_cmd), 3);
        chk("R10 victim address", int'(bus_addr), (m_tag[idx] << IDX_W) | idx);
        ack(1'b0);
        m_st[idx] = 0;
      end
      chk(wr ? "R3 read-exclusive issued" : "R2 read issued", int'(bus_cmd), wr ? 2 : 1);
      chk("R2 R3 fill address", int'(bus_addr), int'(a));
      chk("R11 not ready while busy", int'(req_ready), 0);
      ack(sh);
      chk("R12 miss response after ack", int'(resp_valid), 1);
      chk("R2 R3 miss flag", int'(resp_hit), 0);
      chk(wr ? "R3 fill state" : "R2 fill state", int'(resp_state), fill_st(wr, sh));
      chk("R12 bus idle after fill", int'(bus_cmd), 0);
      m_st[idx] = fill_st(wr, sh);
      m_tag[idx] = tg;
    end
  endtask

  task automatic snoop_op(input bit ex, input logic [LINE_AW-1:0] a, input bit with_req);
    int idx, tg, st;
    bit hit;
    idx = int'(a[IDX_W-1:0]);
    tg  = int'(a[LINE_AW-1:IDX_W]);
    st  = m_st[idx];
    hit = (st != 0) && (m_tag[idx] == tg);
    @(negedge clk);
    snp_valid = 1; snp_excl = ex; snp_addr = a;
    if (with_req) begin
      req_valid = 1; req_write = 0; req_addr = a;
      #1 chk("R11 ready low on snoop to same index", int'(req_ready), 0);
    end
    @(negedge clk);
    snp_valid = 0; snp_excl = 0; req_valid = 0;
    chk(hit ? (ex ? "R8 no shared on rdx" : "R6 shared on read") : "R9 miss no shared",
        int'(snp_shared), (hit && !ex) ? 1 : 0);
    chk(hit ? "R7 flush on Modified" : "R9 miss no flush", int'(snp_flush), (hit && st == 3) ? 1 : 0);
    if (hit && st == 3) chk("R7 flush address", int'(snp_flush_addr), int'(a));
    if (with_req) chk("R11 stalled request not answered", int'(resp_valid), 0);
    if (hit) m_st[idx] = ex ? 0 : 1;
  endtask

  function automatic logic [LINE_AW-1:0] mk(input int tg, input int idx);
    return LINE_AW'((tg << IDX_W) | idx);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5E_0C0F));
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 bus idle", int'(bus_cmd), 0);
    chk("R1 no response", int'(resp_valid), 0);
    chk("R1 no shared", int'(snp_shared), 0);
    chk("R1 no flush", int'(snp_flush), 0);
    chk("R1 ready", int'(req_ready), 1);
    // directed sequence on index 1
    proc_op(0, mk(0, 1), 0);   // R1 R2 miss into E
    proc_op(0, mk(0, 1), 1);   // R5 read hit E
    proc_op(1, mk(0, 1), 0);   // R4 E to M silently
    proc_op(0, mk(0, 1), 0);   // R5 read hit M
    proc_op(1, mk(0, 1), 0);   // R5 write hit M
    snoop_op(0, mk(0, 1), 0);  // R6 R7 M to S with flush
    proc_op(1, mk(0, 1), 0);   // R3 S upgrade
    snoop_op(1, mk(0, 1), 0);  // R7 R8 M to I
    proc_op(0, mk(0, 1), 1);   // R2 miss into S
    snoop_op(0, mk(1, 1), 0);  // R9 tag mismatch
    snoop_op(1, mk(2, 1), 0);  // R9 tag mismatch rdx
    proc_op(0, mk(0, 1), 0);   // R9 line unchanged, still S hit
    proc_op(1, mk(1, 1), 1);   // R10 silent S victim, R3 into M
    proc_op(0, mk(2, 1), 0);   // R10 M victim written back
    snoop_op(0, mk(2, 1), 1);  // R11 same-index stall, R6 on E
    proc_op(0, mk(2, 1), 0);   // R5 now S
    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [LINE_AW-1:0] a;
      op = int'($urandom % 4);
      a  = mk(int'($urandom % 3), int'($urandom % 4));
      if (op < 2) proc_op(op[0], a, 1'($urandom));
      else        snoop_op(op == 3, a, 1'($urandom % 8 == 0));
    end
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule